// File: doc/BRIEF.md
# Bypassing Register File

This block is the general-purpose register store of a five-stage pipelined core. It holds a parameterised set of words (thirty-two 32-bit registers by default). Two combinational read ports serve the decode stage, and one clocked write port serves write-back. Register zero always reads as zero and cannot be changed. A synchronous active-high reset clears every register.

The write data can appear on a read port in the same cycle it is written. When write-back commits a register that decode is reading in that cycle, each read port whose address equals the active, nonzero write address returns the incoming write data rather than the stored word. The two ports decide this independently. This lets write-back and decode of one register overlap in a single cycle, which removes one stall slot from software-scheduled hazard padding.

All pins are plain level signals. Reads are combinational, and a write is committed at the next rising clock edge.

Top module: `regfile_bypass`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared. After reset, with `wr_en` low, every read address returns zero.
- R2: With `wr_en` high and `wr_addr` nonzero, `wr_data` is stored into register `wr_addr` at the rising edge. Later reads of that address return it.
- R3: With `wr_en` low, a rising edge changes no register, whatever `wr_addr` and `wr_data` are.
- R4: In any cycle where `wr_en` is high, `wr_addr` is nonzero and `rd_addr_a` equals `wr_addr`, `rd_data_a` equals `wr_data` in that same cycle.
- R5: Port B applies the bypass rule of R4 on its own, comparing `rd_addr_b` with `wr_addr`, whatever port A is reading.
- R6: If a read address equals `wr_addr` while `wr_en` is low, that port returns the stored word, not `wr_data`.
- R7: A read of address 0 on either port returns zero in every cycle, including while a write to address 0 is being presented.
- R8: A write to address 0 has no effect. Address 0 still reads zero afterwards, and no other register changes.
- R9: The two ports return two different registers in the same cycle, each matching its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_addr_a | input | 5 | Read address, port A (source operand 1) |
| rd_data_a | output | 32 | Read data, port A |
| rd_addr_b | input | 5 | Read address, port B (source operand 2) |
| rd_data_b | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable; also gates the bypass |
| wr_addr | input | 5 | Write address (destination register) |
| wr_data | input | 32 | Write data |

## Verification
The bench targets the same-cycle overlap of write and read: one port matching, both ports matching, and neither matching. A design without the bypass would return the previous stored word on the matching port. It also presents a matching address with the enable low, where a bypass that ignores the enable would leak uncommitted data. It drives writes to address 0 while reading address 0, which catches a bypass that forgets the zero exclusion or a storage word that accepts the write. Disabled writes to live registers are checked afterwards through the read ports, and a design that fails to gate storage on the enable would corrupt them.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int unsigned RF_DATA_W = 32;
  localparam int unsigned RF_NREGS  = 32;
  localparam int unsigned RF_NPORTS = 2;

  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_STORED = 2'd1,
    SRC_BYPASS = 2'd2
  } rd_src_e;

endpackage

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NREGS  = RF_NREGS,
  localparam int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word_q [NREGS]
);

  // Word 0 has no flop; every other word is a separate enabled register
  for (genvar gi = 0; gi < NREGS; gi++) begin : g_word
    if (gi == 0) begin : g_zero
      assign word_q[gi] = '0;
    end else begin : g_live
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(gi));

      always_ff @(posedge clk) begin
        if (rst) begin
          word_q[gi] <= '0;
        end else if (hit) begin
          word_q[gi] <= wr_data;
        end
      end

      // R1: a cycle after reset is sampled, the word is clear
      assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (word_q[gi] == '0));

      // R3: a word untouched by an enabled write keeps its value
      assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_addr == ADDR_W'(gi))) |=> $stable(word_q[gi]));
    end
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NREGS  = RF_NREGS,
  localparam int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic [DATA_W-1:0] word_q [NREGS],
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  rd_src_e src;

  always_comb begin
    if (rd_addr == '0) begin
      src = SRC_ZERO;
    end else if (wr_en && (wr_addr == rd_addr)) begin
      src = SRC_BYPASS;
    end else begin
      src = SRC_STORED;
    end
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:   rd_data = '0;
      SRC_BYPASS: rd_data = wr_data;
      SRC_STORED: rd_data = word_q[rd_addr];
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
  import rf_pkg::*;
#(
  parameter int unsigned DATA_W = RF_DATA_W,
  parameter int unsigned NREGS  = RF_NREGS,
  localparam int unsigned ADDR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int unsigned NPORTS = RF_NPORTS;

  logic [DATA_W-1:0] word_q   [NREGS];
  logic [ADDR_W-1:0] port_adr [NPORTS];
  logic [DATA_W-1:0] port_dat [NPORTS];

  assign port_adr[0] = rd_addr_a;
  assign port_adr[1] = rd_addr_b;
  assign rd_data_a   = port_dat[0];
  assign rd_data_b   = port_dat[1];

  rf_storage #(.DATA_W(DATA_W), .NREGS(NREGS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .word_q  (word_q)
  );

  for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
    rf_read_port #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rd (
      .word_q  (word_q),
      .rd_addr (port_adr[gp]),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_data (port_dat[gp])
    );
  end

  // R4: same-cycle bypass on port A
  assert_bypass_a_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr != '0) && (rd_addr_a == wr_addr)) |-> (rd_data_a == wr_data));

  // R5: same-cycle bypass on port B
  assert_bypass_b_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr != '0) && (rd_addr_b == wr_addr)) |-> (rd_data_b == wr_data));

  // R7: address zero reads zero on both ports
  assert_zero_read_R7: assert property (@(posedge clk) disable iff (rst)
    ((rd_addr_a == '0) |-> (rd_data_a == '0)) and ((rd_addr_b == '0) |-> (rd_data_b == '0)));

  // R2: a committed write is returned by a read of that address one cycle later
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ($past(wr_addr) != '0) &&
     (rd_addr_a == $past(wr_addr)) && !(wr_en && (wr_addr == rd_addr_a)))
    |-> (rd_data_a == $past(wr_data)));

endmodule

// File: tb/sim_regfile_bypass.sv
`timescale 1ns/1ps
module sim_regfile_bypass;

  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] rd_addr_a = '0;
  logic [AW-1:0] rd_addr_b = '0;
  logic [DW-1:0] rd_data_a;
  logic [DW-1:0] rd_data_b;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] model [NR];

  always #5 clk = ~clk;

  regfile_bypass u0 (
    .clk       (clk),
    .rst       (rst),
    .rd_addr_a (rd_addr_a),
    .rd_data_a (rd_data_a),
    .rd_addr_b (rd_addr_b),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    if (a == '0) return '0;
    if (wr_en && (wr_addr == a)) return wr_data;
    return model[a];
  endfunction

  function automatic string tag_for(input logic [AW-1:0] a);
    if (a == '0) return "R7";
    if (wr_en && (wr_addr == a)) return "R4/R5";
    if (!wr_en && (wr_addr == a)) return "R6";
    return "R2";
  endfunction

  task automatic compare(input string req, input string port,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %s: actual %h expected %h", req, port, act, exp);
    end
  endtask

  // One cycle: drive after the falling edge, check, then commit to the model.
  task automatic cycle(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input logic [AW-1:0] ra, input logic [AW-1:0] rb, input string req);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr_a = ra; rd_addr_b = rb;
    #2;
    if (!rst) begin
      compare((req == "") ? tag_for(ra) : req, "A", rd_data_a, expect_rd(ra));
      compare((req == "") ? tag_for(rb) : req, "B", rd_data_b, expect_rd(rb));
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
    end else if (we && (wa != '0)) begin
      model[wa] = wd;
    end
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    @(negedge clk);
    cycle(1'b1, 5'd3, 32'hDEAD_BEEF, 5'd3, 5'd4, "");
    cycle(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "");
    rst = 1'b0;
    // R1: everything clear after reset
    for (int i = 0; i < NR; i += 2) cycle(1'b0, 5'd0, 32'h0, AW'(i), AW'(i + 1), "R1");
    // R2: fill registers, then read back pairs (R9: different registers per port)
    for (int i = 1; i < NR; i++) cycle(1'b1, AW'(i), 32'h1000_0000 + 32'(i * 7), 5'd0, 5'd0, "R7");
    for (int i = 1; i < NR - 1; i++) cycle(1'b0, 5'd0, 32'h0, AW'(i), AW'(i + 1), "R9");
    // R3: disabled write to live register, then read it back
    cycle(1'b0, 5'd6, 32'hBAD0_0006, 5'd1, 5'd2, "");
    cycle(1'b0, 5'd0, 32'h0, 5'd6, 5'd6, "R3");
    // R6: matching address with enable low returns stored value
    cycle(1'b0, 5'd9, 32'hFFFF_0009, 5'd9, 5'd9, "R6");
    // R4: bypass on A only, R5: bypass on B only, then both
    cycle(1'b1, 5'd10, 32'hA0A0_0010, 5'd10, 5'd11, "R4");
    cycle(1'b1, 5'd12, 32'hB0B0_0012, 5'd11, 5'd12, "R5");
    cycle(1'b1, 5'd13, 32'hC0C0_0013, 5'd13, 5'd13, "R4");
    cycle(1'b0, 5'd0, 32'h0, 5'd10, 5'd13, "R2");
    // R7/R8: write to register zero while reading it, then confirm
    cycle(1'b1, 5'd0, 32'h5555_AAAA, 5'd0, 5'd0, "R7");
    cycle(1'b0, 5'd0, 32'h0, 5'd0, 5'd1, "R8");
    for (int i = 1; i < NR; i += 2) cycle(1'b0, 5'd0, 32'h0, AW'(i), AW'(i + 1), "R8");
    // Mixed traffic in a small address window to provoke matches
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] wa, ra, rb;
      wa = AW'($urandom % 6);
      ra = AW'($urandom % 6);
      rb = ((n % 5) == 0) ? wa : AW'($urandom % 6);
      cycle(1'($urandom % 2), wa, $urandom, ra, rb, "");
    end
    // R1: reset mid-run clears stored state
    rst = 1'b1;
    cycle(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "");
    rst = 1'b0;
    for (int i = 0; i < NR; i += 2) cycle(1'b0, 5'd0, 32'h0, AW'(i), AW'(i + 1), "R1");
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule